// File: doc/BRIEF.md
# Graphic LCD Controller Command Interpreter

This block is the instruction-handling core of a small monochrome graphic LCD controller. A host drives a byte-wide bus made of a register-select line, a read/write line, an 8-bit data byte and a one-cycle strobe. Strobed bytes with register select low and read/write low are instructions. They are decoded into configuration registers: reverse video, entire-display-on, bias, COM scan direction, power control, regulator ratio and a static indicator. The static indicator is loaded by a two-byte sequence.

Strobed accesses with register select high are display data accesses. They step an 8-bit column address that wraps after its last column. A modify-read mode freezes the address on reads only. A pixel mapper turns display RAM bits into on/off drive values, using the reverse and entire-on settings. The column address can be loaded directly through a load port. Every configuration register is visible at the block's ports.

Top module: `lcd_cmd_core`

## Requirements
- R1: While rst_ni is low, and after it rises, every configuration output is 0, col_o is 0, modify-read is off and no static indicator byte is pending.
- R2: Instruction 0xA6/0xA7 sets rev_o to data bit 0. With all_on_o low, pixel_o equals ram_bit_i when rev_o is 0 and its inverse when rev_o is 1.
- R3: Instruction 0xA4/0xA5 sets all_on_o to data bit 0. While all_on_o is 1, pixel_o is 1 whatever ram_bit_i and rev_o are.
- R4: Instruction 0xA2/0xA3 sets bias_o to data bit 0. A byte of the form 1100 S xxx sets shl_o to S (bit 3), and bits 2..0 are ignored.
- R5: A byte 00101 abc sets pwr_o to abc. A byte 00100 abc sets ratio_o to abc. Neither changes the other field.
- R6: Instruction 0xAC/0xAD sets sind_mode_o to data bit 0 and arms a pending flag. The next instruction byte only loads sind_o with its bits 1..0 and is not decoded as a command. The flag then clears.
- R7: A strobe with rs_i=1 and rw_i=0 (write) or rw_i=1 (read) advances col_o by one. The new value appears one cycle after the strobe, and the value after column 131 is 0.
- R8: After 0xE0, modify_read_o is 1, data reads leave col_o unchanged and data writes still advance it. After 0xEE, modify_read_o is 0 and reads advance col_o again.
- R9: Instruction 0xE2 returns every configuration output, modify_read_o, the pending flag and col_o to 0.
- R10: col_load_i=1 loads col_val_i into col_o one cycle later. This takes priority over a data access in the same cycle.
- R11: A byte with rs_i=0 and rw_i=1, or any byte presented without stb_i, changes no configuration output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stb_i | input | 1 | One-cycle bus strobe |
| rs_i | input | 1 | Register select: 0 instruction, 1 display data |
| rw_i | input | 1 | 0 write, 1 read |
| data_i | input | 8 | Bus byte |
| col_load_i | input | 1 | Direct column load |
| col_val_i | input | 8 | Column load value |
| ram_bit_i | input | 1 | Display RAM bit to map |
| pixel_o | output | 1 | Mapped pixel drive (1 = on) |
| col_o | output | 8 | Column address |
| rev_o | output | 1 | Reverse video |
| all_on_o | output | 1 | Entire display on |
| bias_o | output | 1 | Bias select (0 = 1/7, 1 = 1/9) |
| shl_o | output | 1 | COM scan direction (1 = reversed) |
| pwr_o | output | 3 | Power control field |
| ratio_o | output | 3 | Regulator resistor ratio |
| sind_mode_o | output | 1 | Static indicator mode |
| sind_o | output | 2 | Static indicator register |
| modify_read_o | output | 1 | Modify-read mode active |

## Verification
Every register result (configuration outputs, modify-read, pending flag and column address) is due one cycle after the strobed edge. pixel_o follows ram_bit_i combinationally from the registered settings. The bench drives each bus cycle at a falling edge and drops the strobe at the next falling edge, so exactly one rising edge sees it. Register outputs are checked at that falling edge, and pixel_o is checked a nanosecond after ram_bit_i changes. A separate edge advances the column address only for a data access, so a read under modify-read must leave it unchanged across that same single edge.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  typedef struct packed {
    logic       rev;
    logic       all_on;
    logic       bias;
    logic       shl;
    logic [2:0] pwr;
    logic [2:0] ratio;
    logic       sind_mode;
    logic [1:0] sind;
  } lcd_cfg_t;

  localparam logic [6:0] OP_REV    = 7'b1010011;
  localparam logic [6:0] OP_ALLON  = 7'b1010010;
  localparam logic [6:0] OP_BIAS   = 7'b1010001;
  localparam logic [6:0] OP_SIND   = 7'b1010110;
  localparam logic [3:0] OP_SHL    = 4'b1100;
  localparam logic [4:0] OP_PWR    = 5'b00101;
  localparam logic [4:0] OP_RATIO  = 5'b00100;
  localparam logic [7:0] OP_MR_SET = 8'hE0;
  localparam logic [7:0] OP_MR_CLR = 8'hEE;
  localparam logic [7:0] OP_RESET  = 8'hE2;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] data_i,
  output lcd_cfg_t   cfg_o,
  output logic       mod_read_o,
  output logic       soft_rst_o
);

  lcd_cfg_t cfg_q, cfg_d;
  logic     mr_q, mr_d;
  logic     pend_q, pend_d;
  logic     cmd_stb;

  assign cmd_stb    = stb_i && !rs_i && !rw_i;
  assign soft_rst_o = cmd_stb && !pend_q && (data_i == OP_RESET);

  always_comb begin
    cfg_d  = cfg_q;
    mr_d   = mr_q;
    pend_d = pend_q;
    if (cmd_stb) begin
      if (pend_q) begin
        // armed: byte only feeds the indicator register
        cfg_d.sind = data_i[1:0];
        pend_d     = 1'b0;
      end else if (data_i == OP_RESET) begin
        cfg_d = '0;
        mr_d  = 1'b0;
      end else if (data_i == OP_MR_SET) begin
        mr_d = 1'b1;
      end else if (data_i == OP_MR_CLR) begin
        mr_d = 1'b0;
      end else if (data_i[7:1] == OP_REV) begin
        cfg_d.rev = data_i[0];
      end else if (data_i[7:1] == OP_ALLON) begin
        cfg_d.all_on = data_i[0];
      end else if (data_i[7:1] == OP_BIAS) begin
        cfg_d.bias = data_i[0];
      end else if (data_i[7:1] == OP_SIND) begin
        cfg_d.sind_mode = data_i[0];
        pend_d          = 1'b1;
      end else if (data_i[7:4] == OP_SHL) begin
        cfg_d.shl = data_i[3];
      end else if (data_i[7:3] == OP_PWR) begin
        cfg_d.pwr = data_i[2:0];
      end else if (data_i[7:3] == OP_RATIO) begin
        cfg_d.ratio = data_i[2:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mr_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      mr_q   <= mr_d;
      pend_q <= pend_d;
    end
  end

  assign cfg_o      = cfg_q;
  assign mod_read_o = mr_q;

  // R6
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && cmd_stb |=> !pend_q);

  // R6
  pend_no_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && cmd_stb |=> $stable(mr_q) && $stable(cfg_q.rev) && $stable(cfg_q.all_on)
                          && $stable(cfg_q.pwr) && $stable(cfg_q.sind_mode));

  // R9
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (cfg_q == '0) && !mr_q && !pend_q);

  // R11
  no_cmd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_stb |=> $stable(cfg_q) && $stable(mr_q));

endmodule

// File: rtl/lcd_col_ctr.sv
module lcd_col_ctr #(
  parameter int COL_W    = 8,
  parameter int COL_LAST = 131
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_val_i,
  input  logic             acc_i,
  input  logic             rd_i,
  input  logic             mod_read_i,
  output logic [COL_W-1:0] col_o
);

  localparam logic [COL_W-1:0] LAST = COL_W'(COL_LAST);

  logic [COL_W-1:0] col_q, col_d;
  logic             step;

  assign step = acc_i && !(rd_i && mod_read_i);

  always_comb begin
    col_d = col_q;
    if (clr_i)        col_d = '0;
    else if (load_i)  col_d = load_val_i;
    else if (step)    col_d = (col_q == LAST) ? '0 : col_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= '0;
    else         col_q <= col_d;
  end

  assign col_o = col_q;

  // R7
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !rd_i && !load_i && !clr_i && (col_q == LAST) |=> col_q == '0);

  // R8
  mr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && rd_i && mod_read_i && !load_i && !clr_i |=> $stable(col_q));

  // R10
  col_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> col_q == $past(load_val_i));

endmodule

// File: rtl/lcd_pix_map.sv
module lcd_pix_map #(
  parameter int LANES = 1
) (
  input  logic             rev_i,
  input  logic             all_on_i,
  input  logic [LANES-1:0] ram_i,
  output logic [LANES-1:0] pix_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pix_o[g] = all_on_i | (ram_i[g] ^ rev_i);
  end

endmodule

// File: rtl/lcd_cmd_core.sv
module lcd_cmd_core
  import lcd_cmd_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int COL_LAST = 131
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             rs_i,
  input  logic             rw_i,
  input  logic [7:0]       data_i,
  input  logic             col_load_i,
  input  logic [COL_W-1:0] col_val_i,
  input  logic             ram_bit_i,
  output logic             pixel_o,
  output logic [COL_W-1:0] col_o,
  output logic             rev_o,
  output logic             all_on_o,
  output logic             bias_o,
  output logic             shl_o,
  output logic [2:0]       pwr_o,
  output logic [2:0]       ratio_o,
  output logic             sind_mode_o,
  output logic [1:0]       sind_o,
  output logic             modify_read_o
);

  lcd_cfg_t cfg;
  logic     mod_read;
  logic     soft_rst;

  lcd_cmd_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb_i),
    .rs_i       (rs_i),
    .rw_i       (rw_i),
    .data_i     (data_i),
    .cfg_o      (cfg),
    .mod_read_o (mod_read),
    .soft_rst_o (soft_rst)
  );

  lcd_col_ctr #(.COL_W(COL_W), .COL_LAST(COL_LAST)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst),
    .load_i     (col_load_i),
    .load_val_i (col_val_i),
    .acc_i      (stb_i && rs_i),
    .rd_i       (rw_i),
    .mod_read_i (mod_read),
    .col_o      (col_o)
  );

  lcd_pix_map #(.LANES(1)) u_pix (
    .rev_i    (cfg.rev),
    .all_on_i (cfg.all_on),
    .ram_i    (ram_bit_i),
    .pix_o    (pixel_o)
  );

  assign rev_o         = cfg.rev;
  assign all_on_o      = cfg.all_on;
  assign bias_o        = cfg.bias;
  assign shl_o         = cfg.shl;
  assign pwr_o         = cfg.pwr;
  assign ratio_o       = cfg.ratio;
  assign sind_mode_o   = cfg.sind_mode;
  assign sind_o        = cfg.sind;
  assign modify_read_o = mod_read;

  // R3
  all_on_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_on_o |-> pixel_o);

  // R2
  rev_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_on_o |-> pixel_o == (ram_bit_i != rev_o));

endmodule

// File: tb/tb_lcd_cmd_core.sv
`timescale 1ns/1ps
module tb_lcd_cmd_core;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       stb = 0, rs = 0, rw = 0, ld = 0, ram = 0;
  logic [7:0] dat = 0, ldv = 0;
  logic       pixel, rev, all_on, bias, shl, smode, mr;
  logic [7:0] col;
  logic [2:0] pwr, ratio;
  logic [1:0] sind;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  lcd_cmd_core dut (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .rs_i(rs), .rw_i(rw), .data_i(dat),
    .col_load_i(ld), .col_val_i(ldv), .ram_bit_i(ram), .pixel_o(pixel), .col_o(col),
    .rev_o(rev), .all_on_o(all_on), .bias_o(bias), .shl_o(shl), .pwr_o(pwr),
    .ratio_o(ratio), .sind_mode_o(smode), .sind_o(sind), .modify_read_o(mr)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one bus cycle: exactly one rising edge sees the strobe
  task automatic cycle(logic s, logic r_s, logic r_w, logic [7:0] d, logic l, logic [7:0] lv);
    @(negedge clk);
    stb = s; rs = r_s; rw = r_w; dat = d; ld = l; ldv = lv;
    @(negedge clk);
    stb = 0; ld = 0;
  endtask

  task automatic cmd(logic [7:0] d);     cycle(1, 0, 0, d, 0, 0); endtask
  task automatic dwrite();               cycle(1, 1, 0, 8'h55, 0, 0); endtask
  task automatic dread();                cycle(1, 1, 1, 8'h00, 0, 0); endtask
  task automatic load(logic [7:0] v);    cycle(0, 0, 0, 0, 1, v); endtask

  task automatic pix(string tag, logic b, int exp);
    ram = b; #1; check(tag, pixel, exp);
  endtask

  task automatic check_defaults(string tag);
    check({tag, " rev"}, rev, 0);       check({tag, " all_on"}, all_on, 0);
    check({tag, " bias"}, bias, 0);     check({tag, " shl"}, shl, 0);
    check({tag, " pwr"}, pwr, 0);       check({tag, " ratio"}, ratio, 0);
    check({tag, " smode"}, smode, 0);   check({tag, " sind"}, sind, 0);
    check({tag, " mr"}, mr, 0);         check({tag, " col"}, col, 0);
  endtask

  task automatic t_reset();
    check_defaults("R1 reset");
    cmd(8'hAD); cmd(8'hA5); load(8'd9);
    @(negedge clk); rst_n = 0; #1;
    check_defaults("R1 in reset");
    @(negedge clk); rst_n = 1;
    cmd(8'hA7);
    check("R1 pending cleared by reset", rev, 1);
    check("R1 sind untouched", sind, 0);
    cmd(8'hA6);
  endtask

  task automatic t_rev();
    pix("R2 rev0 ram1", 1, 1); pix("R2 rev0 ram0", 0, 0);
    cmd(8'hA7); check("R2 rev set", rev, 1);
    pix("R2 rev1 ram1", 1, 0); pix("R2 rev1 ram0", 0, 1);
    cmd(8'hA6); check("R2 rev clr", rev, 0);
    pix("R2 rev back ram1", 1, 1);
  endtask

  task automatic t_all_on();
    cmd(8'hA7); cmd(8'hA5); check("R3 all_on set", all_on, 1);
    pix("R3 all_on ram0", 0, 1); pix("R3 all_on ram1", 1, 1);
    cmd(8'hA4); check("R3 all_on clr", all_on, 0);
    pix("R3 after off ram1", 1, 0);
    cmd(8'hA6);
  endtask

  task automatic t_bias_shl();
    cmd(8'hA3); check("R4 bias 1", bias, 1);
    cmd(8'hCF); check("R4 shl 1 low bits dc", shl, 1);
    cmd(8'hC7); check("R4 shl 0", shl, 0);
    cmd(8'hA2); check("R4 bias 0", bias, 0);
  endtask

  task automatic t_pwr_ratio();
    cmd(8'h2D); check("R5 pwr", pwr, 5);
    cmd(8'h23); check("R5 ratio", ratio, 3); check("R5 pwr kept", pwr, 5);
    cmd(8'h2A); check("R5 pwr 2", pwr, 2); check("R5 ratio kept", ratio, 3);
  endtask

  task automatic t_sind();
    cmd(8'hAD); check("R6 mode 1", smode, 1);
    cmd(8'hA7); check("R6 sind 3", sind, 3); check("R6 not decoded", rev, 0);
    cmd(8'hA7); check("R6 pending cleared", rev, 1);
    cmd(8'hA6);
    cmd(8'hAC); check("R6 mode 0", smode, 0);
    cmd(8'hE0); check("R6 E0 consumed", mr, 0); check("R6 sind from E0", sind, 0);
    cmd(8'hAC); cmd(8'h02); check("R6 sind 2", sind, 2);
  endtask

  task automatic t_ignore();
    cycle(1, 0, 1, 8'hA7, 0, 0); check("R11 rw=1 ignored", rev, 0);
    cycle(0, 0, 0, 8'hA5, 0, 0); check("R11 no strobe ignored", all_on, 0);
    cycle(0, 0, 0, 8'h2F, 0, 0); check("R11 no strobe pwr", pwr, 2);
  endtask

  task automatic t_col();
    load(8'd5); check("R10 load", col, 5);
    dwrite(); check("R7 write inc", col, 6);
    dread();  check("R7 read inc", col, 7);
    cycle(1, 1, 0, 8'h00, 1, 8'd40); check("R10 load beats access", col, 40);
    load(8'd131); dwrite(); check("R7 wrap", col, 0);
    load(8'd130); dread(); check("R7 to last", col, 131);
  endtask

  task automatic t_mr();
    load(8'd10);
    cmd(8'hE0); check("R8 mr on", mr, 1);
    dread();  check("R8 read holds", col, 10);
    dwrite(); check("R8 write inc", col, 11);
    cmd(8'hEE); check("R8 mr off", mr, 0);
    dread();  check("R8 read inc again", col, 12);
  endtask

  task automatic t_soft();
    cmd(8'hA7); cmd(8'hA5); cmd(8'hA3); cmd(8'hC8); cmd(8'h2F); cmd(8'h27);
    cmd(8'hAD); cmd(8'h03); cmd(8'hE0); load(8'd77);
    cmd(8'hE2);
    check_defaults("R9 soft reset");
    cmd(8'hAD); cmd(8'hE2);
    check("R9 E2 as sind byte", sind, 2); check("R9 mode kept", smode, 1);
    cmd(8'hE2); check("R9 second E2", smode, 0);
  endtask

  initial begin
    #25 rst_n = 1;
    t_reset();
    t_rev();
    t_all_on();
    t_bias_shl();
    t_pwr_ratio();
    t_sind();
    t_ignore();
    t_col();
    t_mr();
    t_soft();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule